// File: doc/BRIEF.md
# Row-Latched Data EEPROM Controller

This block fronts a small byte-wide non-volatile data store. Reads come straight from the cell array when the controller is in read mode. To change stored data, software first turns on latch mode, then writes bytes into a row-sized bank of data latches. It then starts a programming cycle that copies every written latch into one row of the array. The cycle runs for a fixed number of clocks. When it ends, the controller drops back to read mode by itself.

A CPU-side bus carries byte reads and writes to the array and accesses to an 8-bit control/status register. A wait request from the power manager is granted at once when the controller is idle and is held off while a cycle runs. A halt request cuts a running cycle short. That abort path discards the staged bytes and leaves the array row as it was, so nothing is guaranteed to have been written.

Top module: `ee_row_ctrl`

## Requirements
- R1: The control/status register reads bit 1 as latch mode and bit 0 as the program/busy flag. Bits 7:2 always read 0, and the register is 00h after reset.
- R2: While latch mode is off, a read returns the array byte at `mem_addr` in the same cycle with `mem_rdrive` high. While latch mode is on, a read leaves `mem_rdrive` low and `mem_rdata` at 0, so staged bytes cannot be read.
- R3: An array write while latch mode is off changes nothing.
- R4: An array write in latch mode stores the byte in the latch picked by address bits 4:0. The row that is committed comes from address bits 6:5 of the most recent such write.
- R5: A second write to the same latch before commit leaves the bitwise AND of both values.
- R6: A register write with bits 1:0 = 11 while latch mode is already on starts a cycle. `busy` is high for exactly TPROG clocks, and both register bits then clear on the same edge. Only the latches written in the batch update their bytes; the other bytes of the row keep their values.
- R7: While a cycle runs, register writes and array writes are ignored. Clearing latch mode while idle discards every staged byte.
- R8: With no cycle running, `wait_ack` rises on the clock after `wait_req`. During a cycle `wait_ack` stays low, and it rises on the edge where the cycle ends.
- R9: A halt request during a cycle clears both register bits on the next edge, leaves the array row unchanged and discards the latches. A halt request while idle has no effect.
- R10: Writing bits 1:0 = 11 while latch mode is off only turns latch mode on and does not start a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | input | 1 | Array access strobe |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 7 | Byte address in the array |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 8 | Read data, 0 when not driven |
| mem_rdrive | output | 1 | High when the read data bus is driven |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Control/status register write data |
| csr_rdata | output | 8 | Control/status register contents |
| wait_req | input | 1 | Request to enter wait mode |
| wait_ack | output | 1 | Wait mode entered |
| halt_req | input | 1 | Request for immediate halt |
| busy | output | 1 | Programming cycle in progress |

## Verification
The hardest state to reach from the ports is a halt that lands inside a running programming cycle. The row must already hold known data that differs from the staged bytes, and the halt must arrive a few clocks after the cycle starts. To get there, the stimulus first fills the whole array through full-row batches. It then stages a byte, starts a cycle and pulses the halt input mid-cycle. Finally it reads the row back, and the row must still hold its old data. The row-select rule is reached in a similar way: a single batch mixes writes from two rows, and the bench checks where the first byte lands.

// File: rtl/ee_row_pkg.sv
package ee_row_pkg;
    localparam int CSR_W    = 8;
    localparam int BIT_PGM  = 0;
    localparam int BIT_LAT  = 1;

    function automatic logic [CSR_W-1:0] pack_csr(input logic lat, input logic pgm);
        logic [CSR_W-1:0] v;
        v          = '0;
        v[BIT_LAT] = lat;
        v[BIT_PGM] = pgm;
        return v;
    endfunction
endpackage

// File: rtl/ee_ctl.sv
module ee_ctl
    import ee_row_pkg::*;
#(
    parameter int TPROG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_we,
    input  logic [1:0] csr_bits,
    input  logic       halt_req,
    input  logic       wait_req,
    output logic       lat_on,
    output logic       pgm_on,
    output logic       done,
    output logic       abort,
    output logic       lat_fall,
    output logic       wait_ack
);
    localparam int CNT_W = (TPROG > 1) ? $clog2(TPROG) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TPROG - 1);

    typedef struct packed {
        logic             lat;
        logic             pgm;
        logic             wt;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        abort    = 1'b0;
        lat_fall = 1'b0;
        if (st_q.pgm) begin
            if (halt_req) begin
                abort    = 1'b1;
                st_d.pgm = 1'b0;
                st_d.lat = 1'b0;
            end else if (st_q.cnt == '0) begin
                done     = 1'b1;
                st_d.pgm = 1'b0;
                st_d.lat = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (csr_we) begin
            st_d.lat = csr_bits[BIT_LAT];
            if (st_q.lat && csr_bits[BIT_LAT] && csr_bits[BIT_PGM]) begin
                st_d.pgm = 1'b1;
                st_d.cnt = CNT_LOAD;
            end
            if (st_q.lat && !csr_bits[BIT_LAT]) begin
                lat_fall = 1'b1;
            end
        end
        st_d.wt = wait_req && !st_d.pgm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_on   = st_q.lat;
    assign pgm_on   = st_q.pgm;
    assign wait_ack = st_q.wt;
endmodule

// File: rtl/ee_latch_row.sv
module ee_latch_row #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               clr,
    output logic [(1<<IDX_W)-1:0][DATA_W-1:0]  lat_data,
    output logic [(1<<IDX_W)-1:0]              lat_vld,
    output logic [ADDR_W-IDX_W-1:0]            lat_row
);
    localparam int NLAT  = 1 << IDX_W;
    localparam int ROW_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [NLAT-1:0][DATA_W-1:0] data;
        logic [NLAT-1:0]             vld;
        logic [ROW_W-1:0]            row;
    } row_t;

    row_t st_d, st_q;
    logic [IDX_W-1:0] idx;

    assign idx = wr_addr[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.data = '0;
            st_d.vld  = '0;
        end else if (wr_en) begin
            st_d.data[idx] = st_q.vld[idx] ? (st_q.data[idx] & wr_data) : wr_data;
            st_d.vld[idx]  = 1'b1;
            st_d.row       = wr_addr[ADDR_W-1:IDX_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_data = st_q.data;
    assign lat_vld  = st_q.vld;
    assign lat_row  = st_q.row;
endmodule

// File: rtl/ee_cell_array.sv
module ee_cell_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                               clk,
    input  logic                               commit,
    input  logic [(1<<IDX_W)-1:0][DATA_W-1:0]  src_data,
    input  logic [(1<<IDX_W)-1:0]              src_vld,
    input  logic [ADDR_W-IDX_W-1:0]            src_row,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [DATA_W-1:0]                  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NLAT  = 1 << IDX_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [NLAT-1:0][ADDR_W-1:0]  tgt;

    genvar g;
    generate
        for (g = 0; g < NLAT; g++) begin : g_tgt
            assign tgt[g] = {src_row, IDX_W'(g)};
        end
    endgenerate

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int i = 0; i < NLAT; i++) begin
                if (src_vld[i]) mem_d[tgt[i]] = src_data[i];
            end
        end
    end

    // Non-volatile contents: no reset
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ee_row_ctrl.sv
module ee_row_ctrl
    import ee_row_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    parameter int TPROG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rdrive,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              wait_req,
    output logic              wait_ack,
    input  logic              halt_req,
    output logic              busy
);
    localparam int NLAT  = 1 << IDX_W;
    localparam int ROW_W = ADDR_W - IDX_W;

    logic                         lat_on, pgm_on, done, abort, lat_fall;
    logic                         lat_wr, lat_clr;
    logic [NLAT-1:0][DATA_W-1:0]  lat_data;
    logic [NLAT-1:0]              lat_vld;
    logic [ROW_W-1:0]             lat_row;
    logic [DATA_W-1:0]            arr_rd;
    logic                         unused_csr_hi;

    assign unused_csr_hi = ^csr_wdata[CSR_W-1:2];

    ee_ctl #(.TPROG(TPROG)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_we   (csr_we),
        .csr_bits (csr_wdata[1:0]),
        .halt_req (halt_req),
        .wait_req (wait_req),
        .lat_on   (lat_on),
        .pgm_on   (pgm_on),
        .done     (done),
        .abort    (abort),
        .lat_fall (lat_fall),
        .wait_ack (wait_ack)
    );

    assign lat_wr  = mem_req && mem_we && lat_on && !pgm_on;
    assign lat_clr = done || abort || lat_fall;

    ee_latch_row #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lat_wr),
        .wr_addr  (mem_addr),
        .wr_data  (mem_wdata),
        .clr      (lat_clr),
        .lat_data (lat_data),
        .lat_vld  (lat_vld),
        .lat_row  (lat_row)
    );

    ee_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
        .clk      (clk),
        .commit   (done),
        .src_data (lat_data),
        .src_vld  (lat_vld),
        .src_row  (lat_row),
        .rd_addr  (mem_addr),
        .rd_data  (arr_rd)
    );

    assign mem_rdrive = mem_req && !mem_we && !lat_on;
    assign mem_rdata  = mem_rdrive ? arr_rd : '0;
    assign csr_rdata  = pack_csr(lat_on, pgm_on);
    assign busy       = pgm_on;
endmodule

// File: rtl/ee_row_ctrl_chk.sv
module ee_row_ctrl_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_rdrive,
    input logic              csr_we,
    input logic [7:0]        csr_rdata,
    input logic              wait_req,
    input logic              wait_ack,
    input logic              halt_req,
    input logic              busy
);
    AST_CSR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[7:2] == 6'b0); // R1
    AST_BUSY_IS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        busy == csr_rdata[0]); // R1
    AST_NO_DRIVE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && csr_rdata[1]) |-> (!mem_rdrive && mem_rdata == '0)); // R2
    AST_BUSY_NEEDS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> csr_rdata[1]); // R6
    AST_END_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !csr_rdata[1]); // R6
    AST_LAT_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !halt_req && csr_we) |=> (csr_rdata[1] || !busy)); // R7
    AST_NO_WAIT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wait_ack); // R8
    AST_WAIT_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !busy && !csr_we) |=> wait_ack); // R8
    AST_HALT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && halt_req) |=> (!busy && !csr_rdata[1])); // R9
endmodule

bind ee_row_ctrl ee_row_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ee_row_ctrl.sv
module sim_ee_row_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TPROG      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_req = 1'b0, mem_we = 1'b0;
    logic [6:0] mem_addr = '0;
    logic [7:0] mem_wdata = '0;
    logic [7:0] mem_rdata;
    logic       mem_rdrive;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       wait_req = 1'b0, wait_ack;
    logic       halt_req = 1'b0;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_mem [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_row_ctrl #(.TPROG(TPROG)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [7:0] d);
        csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic mem_wr(input int a, input logic [7:0] d);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = 7'(a); mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic mem_chk(input string req, input int a);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = 7'(a);
        #1;
        chk(req, {mem_rdrive, mem_rdata}, {1'b1, exp_mem[a]});
        @(negedge clk);
        mem_req = 1'b0;
    endtask

    // start a cycle and count busy clocks
    task automatic run_cycle(input string req);
        int n;
        csr_wr(8'h03);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(req, n, TPROG);
        chk(req, csr_rdata, 8'h00);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", csr_rdata, 8'h00);
        chk("R1", busy, 0);
        chk("R8", wait_ack, 0);

        // R4/R6 fill every row in full batches
        for (int r = 0; r < 4; r++) begin
            csr_wr(8'hFE);                       // R1 upper bits dropped
            chk("R1", csr_rdata, 8'h02);
            for (int i = 0; i < 32; i++) begin
                mem_wr(r * 32 + i, pat(r * 32 + i));
                exp_mem[r * 32 + i] = pat(r * 32 + i);
            end
            mem_req = 1'b1; mem_addr = 7'(r * 32); #1;
            chk("R2", {mem_rdrive, mem_rdata}, 9'h000);
            @(negedge clk); mem_req = 1'b0;
            run_cycle("R6");
        end
        for (int a = 0; a < 128; a++) mem_chk("R2", a);

        // R3 write in read mode ignored
        mem_wr(5, 8'h00);
        mem_chk("R3", 5);

        // R5 AND on repeat, R6 partial row
        csr_wr(8'h02);
        mem_wr(8'h40, 8'hF0);
        mem_wr(8'h40, 8'h3C);
        mem_wr(8'h47, 8'hA5);
        run_cycle("R6");
        exp_mem[8'h40] = 8'h30;
        exp_mem[8'h47] = 8'hA5;
        mem_chk("R5", 8'h40);
        for (int a = 8'h40; a < 8'h60; a++) mem_chk("R6", a);

        // R4 row taken from last write
        csr_wr(8'h02);
        mem_wr(8'h01, 8'h11);
        mem_wr(8'h62, 8'h22);
        run_cycle("R4");
        exp_mem[8'h61] = 8'h11;
        exp_mem[8'h62] = 8'h22;
        mem_chk("R4", 8'h01);
        mem_chk("R4", 8'h61);
        mem_chk("R4", 8'h62);

        // R7 writes during a cycle ignored
        csr_wr(8'h02);
        mem_wr(8'h10, 8'h55);
        csr_wr(8'h03);
        csr_wr(8'h00);
        chk("R7", csr_rdata, 8'h03);
        mem_wr(8'h11, 8'h66);
        while (busy) @(negedge clk);
        exp_mem[8'h10] = 8'h55;
        mem_chk("R7", 8'h10);
        mem_chk("R7", 8'h11);

        // R7 clearing latch mode discards staged bytes
        csr_wr(8'h02);
        mem_wr(8'h20, 8'h99);
        csr_wr(8'h00);
        csr_wr(8'h02);
        mem_wr(8'h21, 8'h77);
        run_cycle("R7");
        exp_mem[8'h21] = 8'h77;
        mem_chk("R7", 8'h20);
        mem_chk("R7", 8'h21);

        // R10 program bit with latch mode off
        csr_wr(8'h03);
        chk("R10", csr_rdata, 8'h02);
        chk("R10", busy, 0);
        csr_wr(8'h00);

        // R8 wait when idle and during a cycle
        wait_req = 1'b1;
        @(negedge clk);
        chk("R8", wait_ack, 1);
        wait_req = 1'b0;
        @(negedge clk);
        chk("R8", wait_ack, 0);
        csr_wr(8'h02);
        mem_wr(8'h70, 8'h0F);
        csr_wr(8'h03);
        wait_req = 1'b1;
        for (int k = 0; k < TPROG + 2; k++) begin
            chk("R8", wait_ack, !busy);
            @(negedge clk);
        end
        wait_req = 1'b0;
        exp_mem[8'h70] = 8'h0F;
        mem_chk("R8", 8'h70);

        // R9 halt mid-cycle
        csr_wr(8'h02);
        mem_wr(8'h30, ~exp_mem[8'h30]);
        csr_wr(8'h03);
        @(negedge clk);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R9", {busy, csr_rdata}, 9'h000);
        mem_chk("R9", 8'h30);
        // R9 latches discarded: new batch elsewhere leaves 0x30 alone
        csr_wr(8'h02);
        mem_wr(8'h31, 8'h5A);
        run_cycle("R9");
        exp_mem[8'h31] = 8'h5A;
        mem_chk("R9", 8'h30);
        mem_chk("R9", 8'h31);
        // R9 halt while idle
        csr_wr(8'h02);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R9", csr_rdata, 8'h02);
        csr_wr(8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule